// File: doc/BRIEF.md
# USB Endpoint Receive Buffer Engine

This block runs the data phase of an OUT or SETUP transaction inside a USB device controller. A token decoder presents the token type and the endpoint number. If that endpoint exists and is enabled, the engine fetches two words from a per-endpoint descriptor held in a separate 16-bit packet memory. The first word is the buffer start address. The second word is the receive-count word, which encodes how much buffer space the endpoint has.

The engine then takes a stream of received data bytes from the line decoder. It pairs them into halfwords, with the earlier byte of each pair in the low half, and writes them to consecutive buffer locations. It counts the bytes it stores and the space that remains. A byte that finds no space is dropped and marks the packet as overrun.

At end of packet the engine completes the last halfword if one byte is still waiting. It then writes the stored byte count back into the descriptor and reports completion. Completion carries the endpoint, a flag that marks a SETUP transfer, and an ACK request. The ACK request is raised only for a packet with a good CRC, no line error and no overrun.

Top module: `usb_rx_engine`

States, in order:
- `ST_IDLE` waits for a token. An accepted token moves it to `ST_RD_ADDR`.
- `ST_RD_ADDR` reads the address word and always moves to `ST_RD_CNT`.
- `ST_RD_CNT` reads the count word and captures the address. It always moves to `ST_LOAD`.
- `ST_LOAD` captures the count word, loads the space counter and moves to `ST_RECV`.
- `ST_RECV` accepts bytes until end of packet. At end of packet it moves to `ST_FLUSH` if a byte is pending, otherwise to `ST_WBACK`.
- `ST_FLUSH` writes the odd byte and moves to `ST_WBACK`.
- `ST_WBACK` writes the count back and moves to `ST_DONE`.
- `ST_DONE` pulses completion and returns to `ST_IDLE`.

A bus reset takes every state to `ST_IDLE`.

## Requirements
- R1: A token is accepted when `tok_valid` is high in idle, `tok_ep` is below NUM_EP and `ep_en[tok_ep]` is 1. In the next two cycles the engine reads halfword DT_BASE+4*ep+2 (the address word) and then DT_BASE+4*ep+3 (the count word), with `mem_we` low.
- R2: A token for a disabled endpoint, or for an endpoint number of NUM_EP or more, produces no memory access and no completion. Its following bytes and end of packet are also ignored.
- R3: Data bytes are paired LSB-first. Bytes 0x01 then 0x02 are written as 0x0201. Pairs go to consecutive halfword addresses, starting at bits [MAW:1] of the address word.
- R4: The count word holds the block-size flag in bit 15 and a 5-bit block number in bits 14:10. Space is block number × 2 bytes when the flag is 0, and (block number + 1) × 32 bytes when it is 1. The remaining-space counter never rises during reception.
- R5: A byte that arrives when the remaining space is zero is not written, and the packet is marked as overrun.
- R6: At end of packet, a leftover odd byte is written as a halfword with a zero upper byte.
- R7: After the data, the engine writes the count word back to DT_BASE+4*ep+3. Bits 15:10 are kept as read, and bits 9:0 are replaced by the number of bytes stored (modulo 1024). Completion follows in the next cycle.
- R8: `done` pulses for one cycle per accepted packet. `ack_req` is high only together with `done`, and only when `rx_crc_ok` was 1 at end of packet, `rx_err` was never 1 during reception and no overrun occurred.
- R9: `done_setup` reports whether the packet began with a SETUP token, and `done_ep` reports its endpoint.
- R10: `bus_reset` returns the engine to idle. Any pending byte is dropped, and no write-back or completion follows.
- R11: Tokens that arrive while a packet is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_reset | input | 1 | USB bus reset, returns the engine to idle |
| tok_valid | input | 1 | OUT or SETUP token received |
| tok_setup | input | 1 | Token is SETUP (1) or OUT (0) |
| tok_ep | input | 4 | Endpoint number of the token |
| ep_en | input | NUM_EP | Per-endpoint enable mask |
| rx_byte_valid | input | 1 | Received data byte strobe |
| rx_byte | input | 8 | Received data byte |
| rx_eop | input | 1 | End of DATA packet; a byte in the same cycle is dropped |
| rx_crc_ok | input | 1 | CRC result, sampled with rx_eop |
| rx_err | input | 1 | Line error during reception |
| mem_req | output | 1 | Packet memory access |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | MAW | Halfword address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, one cycle after a read |
| done | output | 1 | Packet finished |
| done_setup | output | 1 | Finished packet was SETUP |
| done_ep | output | 4 | Endpoint of finished packet |
| ack_req | output | 1 | Request an ACK handshake |

## Verification
The assertions check four properties on every cycle:
- an accepted token starts a read at once;
- a rejected token leaves the memory port quiet;
- the space counter never rises during reception, and every completion directly follows a write;
- an ACK request never appears without completion, and a bus reset leaves the engine idle.

The bench scenarios show the things a local property cannot, by comparing every memory access and completion against a model:
- the exact halfword contents and addresses;
- the space each count-word encoding yields, at the 32-byte boundary and at zero;
- the odd-byte flush and the written-back count;
- the ACK decision under CRC failure, line error and overrun.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_RD_CNT,
        ST_LOAD,
        ST_RECV,
        ST_FLUSH,
        ST_WBACK,
        ST_DONE
    } rx_state_t;

    // upper part of the receive-count word: block-size flag and block number
    typedef struct packed {
        logic       blk_large;
        logic [4:0] nblk;
    } space_cfg_t;

endpackage

// File: rtl/usb_rx_space_decode.sv
module usb_rx_space_decode
    import usbrx_pkg::*;
#(
    parameter int CW = 16
) (
    input  space_cfg_t      cfg,
    output logic [CW-1:0]   space
);
    localparam int SMALL_SHIFT = 1;
    localparam int LARGE_SHIFT = 5;

    logic [CW-1:0] nblk_w;

    always_comb begin
        nblk_w = CW'(cfg.nblk);
        if (cfg.blk_large) begin
            space = (nblk_w + CW'(1)) << LARGE_SHIFT;
        end else begin
            space = nblk_w << SMALL_SHIFT;
        end
    end
endmodule

// File: rtl/usb_rx_counters.sv
module usb_rx_counters #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          load,
    input  logic [CW-1:0] space,
    input  logic          byte_in,
    output logic          accept,
    output logic [CW-1:0] count,
    output logic [CW-1:0] room,
    output logic          overrun
);
    assign accept = byte_in && (room != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            room    <= '0;
            overrun <= 1'b0;
        end else if (clr) begin
            count   <= '0;
            room    <= '0;
            overrun <= 1'b0;
        end else if (load) begin
            room <= space;
        end else if (byte_in) begin
            if (accept) begin
                room  <= room - CW'(1);
                count <= count + CW'(1);
            end else begin
                overrun <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/usb_rx_packer.sv
module usb_rx_packer #(
    parameter int MAW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           base_load,
    input  logic [MAW-1:0] base,
    input  logic           accept,
    input  logic [7:0]     data_in,
    output logic           wr_valid,
    output logic [MAW-1:0] wr_addr,
    output logic [15:0]    wr_data,
    output logic           odd_pend,
    output logic [7:0]     odd_byte,
    output logic [MAW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            odd_pend <= 1'b0;
            odd_byte <= '0;
            ptr      <= '0;
        end else if (clr) begin
            wr_valid <= 1'b0;
            odd_pend <= 1'b0;
        end else begin
            wr_valid <= 1'b0;
            if (base_load) begin
                ptr <= base;
            end else if (accept) begin
                if (!odd_pend) begin
                    odd_byte <= data_in;
                    odd_pend <= 1'b1;
                end else begin
                    wr_valid <= 1'b1;
                    wr_addr  <= ptr;
                    wr_data  <= {data_in, odd_byte};
                    ptr      <= ptr + MAW'(1);
                    odd_pend <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/usb_rx_engine.sv
module usb_rx_engine
    import usbrx_pkg::*;
#(
    parameter int NUM_EP  = 8,
    parameter int MAW     = 9,
    parameter int DT_BASE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              tok_valid,
    input  logic              tok_setup,
    input  logic [3:0]        tok_ep,
    input  logic [NUM_EP-1:0] ep_en,
    input  logic              rx_byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_eop,
    input  logic              rx_crc_ok,
    input  logic              rx_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [MAW-1:0]    mem_addr,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              done,
    output logic              done_setup,
    output logic [3:0]        done_ep,
    output logic              ack_req
);
    localparam int EPW      = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
    localparam int CW       = 16;
    localparam int ADDR_OFS = 2;
    localparam int CNT_OFS  = 3;

    rx_state_t state, nxt;

    logic [EPW-1:0] ep_q;
    logic           setup_q;
    space_cfg_t     cfg_q;
    logic           err_q;
    logic           crc_q;

    logic           tok_ok;
    logic           tok_go;
    logic           clr;
    logic           byte_in;
    logic           accept;
    logic [CW-1:0]  space;
    logic [CW-1:0]  count;
    logic [CW-1:0]  room;
    logic           ovr;
    logic           wr_valid;
    logic [MAW-1:0] wr_addr;
    logic [15:0]    wr_data;
    logic           odd_pend;
    logic [7:0]     odd_byte;
    logic [MAW-1:0] ptr;
    logic [MAW-1:0] desc_base;

    assign tok_ok    = ({28'd0, tok_ep} < NUM_EP) && ep_en[tok_ep[EPW-1:0]];
    assign tok_go    = (state == ST_IDLE) && tok_valid && tok_ok && !bus_reset;
    assign clr       = tok_go || bus_reset;
    assign byte_in   = (state == ST_RECV) && rx_byte_valid && !rx_eop && !bus_reset;
    assign desc_base = MAW'(DT_BASE) + MAW'({ep_q, 2'b00});

    usb_rx_space_decode #(.CW(CW)) u_space (
        .cfg   (space_cfg_t'(mem_rdata[15:10])),
        .space (space)
    );

    usb_rx_counters #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .load    (state == ST_LOAD),
        .space   (space),
        .byte_in (byte_in),
        .accept  (accept),
        .count   (count),
        .room    (room),
        .overrun (ovr)
    );

    usb_rx_packer #(.MAW(MAW)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .base_load (state == ST_RD_CNT),
        .base      (mem_rdata[MAW:1]),
        .accept    (accept),
        .data_in   (rx_byte),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .odd_pend  (odd_pend),
        .odd_byte  (odd_byte),
        .ptr       (ptr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (bus_reset) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // transfer context captured along the way
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ep_q    <= '0;
            setup_q <= 1'b0;
            cfg_q   <= '0;
            err_q   <= 1'b0;
            crc_q   <= 1'b0;
        end else begin
            if (tok_go) begin
                ep_q    <= tok_ep[EPW-1:0];
                setup_q <= tok_setup;
                err_q   <= 1'b0;
                crc_q   <= 1'b0;
            end
            if (state == ST_LOAD) begin
                cfg_q <= space_cfg_t'(mem_rdata[15:10]);
            end
            if (state == ST_RECV) begin
                if (rx_err) err_q <= 1'b1;
                if (rx_eop) crc_q <= rx_crc_ok;
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (tok_go) nxt = ST_RD_ADDR;
            ST_RD_ADDR: nxt = ST_RD_CNT;
            ST_RD_CNT:  nxt = ST_LOAD;
            ST_LOAD:    nxt = ST_RECV;
            ST_RECV:    if (rx_eop) nxt = odd_pend ? ST_FLUSH : ST_WBACK;
            ST_FLUSH:   nxt = ST_WBACK;
            ST_WBACK:   nxt = ST_DONE;
            ST_DONE:    nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        done       = 1'b0;
        done_setup = 1'b0;
        done_ep    = '0;
        ack_req    = 1'b0;
        unique case (state)
            ST_RD_ADDR: begin
                mem_req  = 1'b1;
                mem_addr = desc_base + MAW'(ADDR_OFS);
            end
            ST_RD_CNT: begin
                mem_req  = 1'b1;
                mem_addr = desc_base + MAW'(CNT_OFS);
            end
            ST_FLUSH: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = ptr;
                mem_wdata = {8'h00, odd_byte};
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_base + MAW'(CNT_OFS);
                mem_wdata = {cfg_q, count[9:0]};
            end
            ST_DONE: begin
                done       = 1'b1;
                done_setup = setup_q;
                done_ep    = 4'(ep_q);
                ack_req    = crc_q && !err_q && !ovr;
            end
            default: begin
                if (wr_valid) begin
                    mem_req   = 1'b1;
                    mem_we    = 1'b1;
                    mem_addr  = wr_addr;
                    mem_wdata = wr_data;
                end
            end
        endcase
    end
endmodule

// File: rtl/usb_rx_engine_chk.sv
module usb_rx_engine_chk
    import usbrx_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_reset,
    input logic          tok_valid,
    input logic          tok_ok,
    input rx_state_t     state,
    input logic          mem_req,
    input logic          mem_we,
    input logic          done,
    input logic          ack_req,
    input logic [CW-1:0] room
);
    assert_fetch_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tok_valid && tok_ok && !bus_reset) |=> (mem_req && !mem_we));

    assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && tok_valid && !tok_ok) |=> !mem_req);

    assert_room_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n || bus_reset)
        (state == ST_RECV && $past(state) == ST_RECV) |-> (room <= $past(room)));

    assert_done_after_wback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req && mem_we));

    assert_ack_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |-> done);

    assert_bus_reset_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (state == ST_IDLE && !mem_req && !done));
endmodule

bind usb_rx_engine usb_rx_engine_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_reset (bus_reset),
    .tok_valid (tok_valid),
    .tok_ok    (tok_ok),
    .state     (state),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .done      (done),
    .ack_req   (ack_req),
    .room      (room)
);

// File: tb/tb_usb_rx_engine.sv
module tb_usb_rx_engine;
    localparam int NUM_EP  = 8;
    localparam int MAW     = 9;
    localparam int DT_BASE = 0;

    typedef struct packed {
        logic [1:0]  kind;   // 0 read, 1 write, 2 completion
        logic [15:0] addr;
        logic [15:0] data;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0;
    logic tok_valid = 1'b0;
    logic tok_setup = 1'b0;
    logic [3:0] tok_ep = '0;
    logic [NUM_EP-1:0] ep_en = 8'b1101_1111;
    logic rx_byte_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic rx_eop = 1'b0;
    logic rx_crc_ok = 1'b0;
    logic rx_err = 1'b0;
    logic mem_req, mem_we;
    logic [MAW-1:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic done, done_setup, ack_req;
    logic [3:0] done_ep;

    int total = 0;
    int bad = 0;
    int obs = 0;
    int cycles = 0;
    bit finished = 1'b0;
    ev_t expq[$];
    string tagq[$];

    always #10 clk = ~clk;

    usb_rx_engine #(.NUM_EP(NUM_EP), .MAW(MAW), .DT_BASE(DT_BASE)) dut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .tok_valid(tok_valid), .tok_setup(tok_setup), .tok_ep(tok_ep), .ep_en(ep_en),
        .rx_byte_valid(rx_byte_valid), .rx_byte(rx_byte), .rx_eop(rx_eop),
        .rx_crc_ok(rx_crc_ok), .rx_err(rx_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .done_setup(done_setup), .done_ep(done_ep), .ack_req(ack_req)
    );

    // packet memory model, preloadable by the bench
    logic [15:0] mem [0:(1<<MAW)-1];
    logic pre_we = 1'b0;
    logic [MAW-1:0] pre_addr = '0;
    logic [15:0] pre_data = '0;
    always @(posedge clk) begin
        if (pre_we) mem[pre_addr] <= pre_data;
        else if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
    end

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // reference comparison on every clock
    always @(negedge clk) begin
        ev_t got;
        ev_t e;
        string t;
        if (rst_n) begin
            if (mem_req) begin
                obs++;
                got.kind = mem_we ? 2'd1 : 2'd0;
                got.addr = 16'(mem_addr);
                got.data = mem_we ? mem_wdata : 16'h0;
                if (expq.size() == 0) begin
                    chk(1'b0, "R2/R10", "unexpected memory access", got, 0);
                end else begin
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk(got == e, t, "memory access", got, e);
                end
            end
            if (done) begin
                obs++;
                got.kind = 2'd2;
                got.addr = 16'({done_setup, done_ep});
                got.data = 16'(ack_req);
                if (expq.size() == 0) begin
                    chk(1'b0, "R2/R10", "unexpected completion", got, 0);
                end else begin
                    e = expq.pop_front();
                    t = tagq.pop_front();
                    chk(got == e, t, "completion", got, e);
                end
            end
            if (ack_req && !done) chk(1'b0, "R8", "ack without done", 1, 0);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            bad++;
            $display("FAIL watchdog expired: actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic push(int k, int a, int d, string t);
        ev_t e;
        e.kind = 2'(k);
        e.addr = 16'(a);
        e.data = 16'(d);
        expq.push_back(e);
        tagq.push_back(t);
    endtask

    task automatic preload(int a, logic [15:0] d);
        pre_we = 1'b1;
        pre_addr = MAW'(a);
        pre_data = d;
        cyc();
        pre_we = 1'b0;
    endtask

    task automatic token(int ep, bit setup);
        tok_valid = 1'b1;
        tok_ep = 4'(ep);
        tok_setup = setup;
        cyc();
        tok_valid = 1'b0;
    endtask

    function automatic logic [7:0] bval(int seed, int i);
        return 8'(seed + i * 37);
    endfunction

    // full packet with reference expectations
    task automatic packet(int ep, bit setup, logic [15:0] baddr, logic [15:0] cw,
                          int n, int seed, bit crc, bit err, int gap, int midtok);
        int space;
        int stored;
        int ptr;
        bit ovr;
        logic [7:0] lo;
        logic [7:0] b;
        preload(DT_BASE + 4 * ep + 2, baddr);
        preload(DT_BASE + 4 * ep + 3, cw);
        space = cw[15] ? (int'(cw[14:10]) + 1) * 32 : int'(cw[14:10]) * 2;  // R4
        push(0, DT_BASE + 4 * ep + 2, 0, "R1");
        push(0, DT_BASE + 4 * ep + 3, 0, "R1");
        stored = 0;
        ptr = int'(baddr[MAW:1]);
        ovr = 1'b0;
        lo = '0;
        for (int i = 0; i < n; i++) begin
            b = bval(seed, i);
            if (stored < space) begin
                if (stored % 2 == 0) lo = b;
                else begin
                    push(1, ptr % (1 << MAW), {b, lo}, "R3");
                    ptr++;
                end
                stored++;
            end else begin
                ovr = 1'b1;  // R5
            end
        end
        if (stored % 2 == 1) push(1, ptr % (1 << MAW), {8'h00, lo}, "R6");
        push(1, DT_BASE + 4 * ep + 3, {cw[15:10], 10'(stored)}, "R7");
        push(2, setup * 16 + ep, (crc && !err && !ovr) ? 1 : 0, "R8/R9");
        token(ep, setup);
        repeat (4) cyc();
        for (int i = 0; i < n; i++) begin
            rx_byte_valid = 1'b1;
            rx_byte = bval(seed, i);
            cyc();
            rx_byte_valid = 1'b0;
            if (i == 0 && err) begin
                rx_err = 1'b1;
                cyc();
                rx_err = 1'b0;
            end
            if (i == 0 && midtok >= 0) token(midtok, 1'b0);  // R11
            repeat (gap) cyc();
        end
        rx_eop = 1'b1;
        rx_crc_ok = crc;
        cyc();
        rx_eop = 1'b0;
        rx_crc_ok = 1'b0;
        repeat (8) cyc();
        chk(expq.size() == 0, "R7", "pending expected events", expq.size(), 0);
        expq.delete();
        tagq.delete();
    endtask

    initial begin
        int o0;
        repeat (3) cyc();
        chk(mem_req == 1'b0, "R10", "reset mem_req", mem_req, 0);
        chk(done == 1'b0 && ack_req == 1'b0, "R8", "reset done/ack", {done, ack_req}, 0);
        rst_n = 1'b1;
        repeat (2) cyc();

        // R3: OUT, 6 bytes back to back, space 8 (flag 0, 4 blocks), stale count field
        packet(1, 1'b0, 16'h0100, {1'b0, 5'd4, 10'h3FF}, 6, 8'h01, 1'b1, 1'b0, 0, -1);
        // R9: SETUP, 8 spaced bytes, space 32
        packet(2, 1'b1, 16'h0140, {1'b1, 5'd0, 10'h000}, 8, 8'h10, 1'b1, 1'b0, 2, -1);
        // R6: odd length, space 64
        packet(3, 1'b0, 16'h0180, {1'b1, 5'd1, 10'h000}, 5, 8'h33, 1'b1, 1'b0, 1, -1);
        // R8: bad CRC
        packet(1, 1'b0, 16'h0100, {1'b0, 5'd4, 10'h000}, 4, 8'h44, 1'b0, 1'b0, 0, -1);
        // R8: line error during reception
        packet(4, 1'b0, 16'h01C0, {1'b0, 5'd8, 10'h000}, 4, 8'h55, 1'b1, 1'b1, 0, -1);
        // R5: overrun with space 4
        packet(6, 1'b0, 16'h0200, {1'b0, 5'd2, 10'h000}, 7, 8'h66, 1'b1, 1'b0, 0, -1);
        // R5: zero space
        packet(7, 1'b0, 16'h0240, {1'b0, 5'd0, 10'h155}, 1, 8'h77, 1'b1, 1'b0, 0, -1);
        // R4: exactly 32 bytes in a 32-byte buffer, then 33
        packet(0, 1'b0, 16'h0280, {1'b1, 5'd0, 10'h000}, 32, 8'h88, 1'b1, 1'b0, 0, -1);
        packet(0, 1'b0, 16'h0280, {1'b1, 5'd0, 10'h000}, 33, 8'h99, 1'b1, 1'b0, 0, -1);
        // R11: token for another valid endpoint during reception
        packet(3, 1'b0, 16'h0180, {1'b0, 5'd3, 10'h000}, 4, 8'hA0, 1'b1, 1'b0, 1, 2);

        // R2: disabled endpoint and out-of-range endpoint
        o0 = obs;
        token(5, 1'b0);
        repeat (4) cyc();
        rx_byte_valid = 1'b1; rx_byte = 8'h5A; cyc(); rx_byte_valid = 1'b0;
        rx_eop = 1'b1; rx_crc_ok = 1'b1; cyc(); rx_eop = 1'b0; rx_crc_ok = 1'b0;
        repeat (6) cyc();
        chk(obs == o0, "R2", "activity for disabled endpoint", obs - o0, 0);
        token(9, 1'b1);
        repeat (4) cyc();
        rx_byte_valid = 1'b1; rx_byte = 8'hA5; cyc(); rx_byte_valid = 1'b0;
        rx_eop = 1'b1; rx_crc_ok = 1'b1; cyc(); rx_eop = 1'b0; rx_crc_ok = 1'b0;
        repeat (6) cyc();
        chk(obs == o0, "R2", "activity for out-of-range endpoint", obs - o0, 0);

        // R10: bus reset in mid-packet drops the pending byte and the write-back
        preload(DT_BASE + 4 * 2 + 2, 16'h0300);
        preload(DT_BASE + 4 * 2 + 3, {1'b0, 5'd8, 10'h000});
        push(0, DT_BASE + 4 * 2 + 2, 0, "R1");
        push(0, DT_BASE + 4 * 2 + 3, 0, "R1");
        push(1, 16'h0300 >> 1, {8'hC2, 8'hC1}, "R3");
        token(2, 1'b0);
        repeat (4) cyc();
        rx_byte_valid = 1'b1;
        rx_byte = 8'hC1; cyc();
        rx_byte = 8'hC2; cyc();
        rx_byte = 8'hC3; cyc();
        rx_byte_valid = 1'b0;
        bus_reset = 1'b1; cyc(); bus_reset = 1'b0;
        rx_eop = 1'b1; rx_crc_ok = 1'b1; cyc(); rx_eop = 1'b0; rx_crc_ok = 1'b0;
        repeat (8) cyc();
        chk(expq.size() == 0, "R10", "events left after bus reset", expq.size(), 0);
        expq.delete();
        tagq.delete();
        // R10: engine restarts cleanly after the reset
        packet(2, 1'b0, 16'h0300, {1'b0, 5'd8, 10'h000}, 2, 8'hD0, 1'b1, 1'b0, 0, -1);

        finish_run();
    end
endmodule